// File: doc/BRIEF.md
# Power-Manager Command Executor with Seconds Clock

This block carries out one power-manager command per dispatch. A transport layer collects the command code and its argument bytes, then pulses a dispatch strobe. One cycle later the block presents a response of up to four bytes and its size. The same edge also carries out any side effect of the command: it loads the seconds clock, raises a one-cycle shutdown or reset request, or updates the device autopoll mask.

The seconds clock is an offset register added to a free-running seconds count. The count advances once every `TICKS_PER_SEC` clock cycles. After reset the clock reads `UNIX_START` plus the fixed distance between the 1904 and 1970 epochs. Setting the clock rewrites only the offset, so the count never stops.

For codes the block does not handle, the caller passes the response length from its own command table. The block returns that many zero bytes, or nothing when the table marks the length as variable.

Top module: `pwr_cmd_exec`

## Requirements
- R1: `rsp_done` is high in exactly the one cycle after each cycle with `cmd_go` high, and is low otherwise. `rsp_size` and `rsp_bytes` are valid while `rsp_done` is high. Response byte i is `rsp_bytes[8i+7:8i]`, and byte 0 is sent first.
- R2: Code 0x38 with zero argument bytes returns 4 bytes: the clock value at the dispatch edge, most significant byte first. Any other argument length returns size 0.
- R3: Code 0x30 with exactly 4 argument bytes sets the clock. Argument byte 0 is the most significant byte. Right after the dispatch edge the clock equals that value, even if a second boundary falls on the same edge. From then on it advances with the seconds count. The response is empty. Any other argument length leaves the clock unchanged.
- R4: After reset the clock equals `UNIX_START + 2082844800`. It increases by one every `TICKS_PER_SEC` cycles after reset is released.
- R5: Code 0x7E with exactly 4 argument bytes returns one 0x00 byte. It also pulses `shutdown_req` together with `rsp_done`, but only if argument bytes 0..3 are 0x4D, 0x41, 0x54, 0x54 ("MATT"). Any other argument length gives size 0 and no request.
- R6: Code 0xD0 with zero argument bytes pulses `reset_req` together with `rsp_done` and returns size 0. Any other argument length gives no request.
- R7: Code 0xEA returns one byte 0x01. Code 0xE2 returns one byte 0x62. Code 0xDC returns one byte 0x00. Code 0xDF returns size 0. None of these checks the argument length.
- R8: Code 0x8F needs at least one argument byte. Subcommands 0x00 and 0x03 in byte 0 return two 0x00 bytes. Subcommands 0x01, 0x02, 0x04 and 0x05 return size 0, as do all other subcommands and an empty argument list.
- R9: Code 0x20 with bytes 0,1 equal to 0x00,0x86 and exactly 4 argument bytes forms the mask {byte2, byte3}. A nonzero mask is loaded into `poll_mask` and sets `poll_on`. A zero mask clears `poll_on` and keeps `poll_mask`. Every other form of code 0x20 changes nothing. Code 0x20 always returns size 0.
- R10: Any other code returns size 0 when `tbl_len_var` is 1. Otherwise it returns size `tbl_rsp_len` with all response bytes zero.
- R11: Response bytes at or beyond `rsp_size` are zero.
- R12: After reset, `rsp_done`, `shutdown_req`, `reset_req`, `poll_on`, `poll_mask` and `rsp_size` are zero. The requests never pulse without `rsp_done`. The autopoll state changes only on a dispatch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_go | input | 1 | Dispatch strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| arg_len | input | 8 | Number of valid argument bytes |
| arg_bytes | input | ARG_BYTES*8 | Argument bytes, byte i at bits 8i+7:8i |
| tbl_rsp_len | input | 8 | Table response length for codes the block does not handle |
| tbl_len_var | input | 1 | Table response length is variable |
| rsp_done | output | 1 | Response valid strobe |
| rsp_size | output | 8 | Response byte count |
| rsp_bytes | output | RSP_BYTES*8 | Response bytes, byte i at bits 8i+7:8i |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |
| poll_mask | output | 16 | Device autopoll mask |
| poll_on | output | 1 | Device autopoll enabled |

## Verification
A clock read or a clock write can be dispatched on the same edge where the prescaler wraps and the seconds count steps. The bench waits until its own edge counter shows the prescaler one cycle before a wrap, then issues a set. It reads the clock back on the next dispatch. That read must return exactly the written value and not one more. A read aligned the same way must still return the value from before the tick. The expected clock is computed from a bench-side model of offset plus edges divided by `TICKS_PER_SEC`.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

   localparam logic [7:0] OP_DEV      = 8'h20;
   localparam logic [7:0] OP_CLK_SET  = 8'h30;
   localparam logic [7:0] OP_CLK_GET  = 8'h38;
   localparam logic [7:0] OP_HALT     = 8'h7E;
   localparam logic [7:0] OP_PWREV    = 8'h8F;
   localparam logic [7:0] OP_RESTART  = 8'hD0;
   localparam logic [7:0] OP_LID      = 8'hDC;
   localparam logic [7:0] OP_READY    = 8'hDF;
   localparam logic [7:0] OP_DLSTAT   = 8'hE2;
   localparam logic [7:0] OP_VER      = 8'hEA;

   localparam logic [7:0] PEV_GET_UP   = 8'h00;
   localparam logic [7:0] PEV_SET_UP   = 8'h01;
   localparam logic [7:0] PEV_CLR_UP   = 8'h02;
   localparam logic [7:0] PEV_GET_WAKE = 8'h03;
   localparam logic [7:0] PEV_SET_WAKE = 8'h04;
   localparam logic [7:0] PEV_CLR_WAKE = 8'h05;

   localparam logic [7:0] DEV_POLL_SEL = 8'h86;

   // Seconds between the 1904 and 1970 epochs
   localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;
   // "MATT", byte 0 first
   localparam logic [31:0] HALT_SIG    = 32'h4D415454;

   localparam logic [7:0] VER_VALUE    = 8'h01;
   localparam logic [7:0] DLSTAT_VALUE = 8'h62;
   localparam logic [7:0] LID_VALUE    = 8'h00;

   typedef struct packed {
      logic        set_clk;
      logic [31:0] clk_val;
      logic        halt;
      logic        restart;
      logic        poll_wr;
      logic [15:0] poll_val;
   } effect_t;

endpackage

// File: rtl/pwr_rtc_keeper.sv
module pwr_rtc_keeper #(
   parameter int unsigned  TICKS_PER_SEC = 50_000_000,
   parameter logic [31:0]  UNIX_START    = 32'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        set_en,
   input  logic [31:0] set_val,
   output logic [31:0] now_sec
);
   import pwr_cmd_pkg::*;

   localparam logic [31:0] START_VALUE = UNIX_START + EPOCH_SHIFT;

   logic        sec_tick;
   logic [31:0] elapsed;
   logic [31:0] elapsed_nxt;
   logic [31:0] offset;

   generate
      if (TICKS_PER_SEC == 1) begin : g_every_cycle
         assign sec_tick = 1'b1;
      end else begin : g_prescale
         localparam int unsigned CW = $clog2(TICKS_PER_SEC);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
         logic [CW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre <= '0;
            end else if (pre == LAST) begin
               pre <= '0;
            end else begin
               pre <= pre + 1'b1;
            end
         end
         assign sec_tick = (pre == LAST);
      end
   endgenerate

   assign elapsed_nxt = elapsed + {31'd0, sec_tick};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= '0;
         offset  <= START_VALUE;
      end else begin
         elapsed <= elapsed_nxt;
         if (set_en) begin
            // referenced to the count after this edge, so a tick here is absorbed
            offset <= set_val - elapsed_nxt;
         end
      end
   end

   assign now_sec = offset + elapsed;

endmodule

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode #(
   parameter int unsigned ARG_BYTES = 4,
   parameter int unsigned RSP_BYTES = 4
) (
   input  logic [7:0]               op,
   input  logic [7:0]               arg_len,
   input  logic [ARG_BYTES*8-1:0]   args,
   input  logic [7:0]               tbl_len,
   input  logic                     tbl_var,
   input  logic [31:0]              now_sec,
   output logic [7:0]               size,
   output logic [RSP_BYTES*8-1:0]   rsp,
   output pwr_cmd_pkg::effect_t     fx
);
   import pwr_cmd_pkg::*;

   logic [7:0] ab [ARG_BYTES];
   logic [7:0] rb [RSP_BYTES];
   logic [31:0] arg_word;

   generate
      for (genvar i = 0; i < ARG_BYTES; i++) begin : g_unpack
         assign ab[i] = args[8*i +: 8];
      end
      for (genvar j = 0; j < RSP_BYTES; j++) begin : g_pack
         assign rsp[8*j +: 8] = rb[j];
      end
   endgenerate

   assign arg_word = {ab[0], ab[1], ab[2], ab[3]};

   always_comb begin
      for (int k = 0; k < RSP_BYTES; k++) begin
         rb[k] = 8'h00;
      end
      size = 8'd0;
      fx   = '0;
      unique case (op)
         OP_CLK_GET: begin
            if (arg_len == 8'd0) begin
               rb[0] = now_sec[31:24];
               rb[1] = now_sec[23:16];
               rb[2] = now_sec[15:8];
               rb[3] = now_sec[7:0];
               size  = 8'd4;
            end
         end
         OP_CLK_SET: begin
            if (arg_len == 8'd4) begin
               fx.set_clk = 1'b1;
               fx.clk_val = arg_word;
            end
         end
         OP_HALT: begin
            if (arg_len == 8'd4) begin
               size    = 8'd1;
               fx.halt = (arg_word == HALT_SIG);
            end
         end
         OP_RESTART: begin
            if (arg_len == 8'd0) begin
               fx.restart = 1'b1;
            end
         end
         OP_VER: begin
            size  = 8'd1;
            rb[0] = VER_VALUE;
         end
         OP_DLSTAT: begin
            size  = 8'd1;
            rb[0] = DLSTAT_VALUE;
         end
         OP_LID: begin
            size  = 8'd1;
            rb[0] = LID_VALUE;
         end
         OP_READY: begin
            size = 8'd0;
         end
         OP_PWREV: begin
            if (arg_len != 8'd0) begin
               case (ab[0])
                  PEV_GET_UP, PEV_GET_WAKE: size = 8'd2;
                  PEV_SET_UP, PEV_CLR_UP,
                  PEV_SET_WAKE, PEV_CLR_WAKE: size = 8'd0;
                  default: size = 8'd0;
               endcase
            end
         end
         OP_DEV: begin
            if (arg_len == 8'd4 && ab[0] == 8'h00 && ab[1] == DEV_POLL_SEL) begin
               fx.poll_wr  = 1'b1;
               fx.poll_val = {ab[2], ab[3]};
            end
         end
         default: begin
            size = tbl_var ? 8'd0 : tbl_len;
         end
      endcase
   end

endmodule

// File: rtl/pwr_cmd_exec.sv
module pwr_cmd_exec #(
   parameter int unsigned ARG_BYTES     = 4,
   parameter int unsigned RSP_BYTES     = 4,
   parameter int unsigned TICKS_PER_SEC = 50_000_000,
   parameter logic [31:0] UNIX_START    = 32'd0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_go,
   input  logic [7:0]             cmd_code,
   input  logic [7:0]             arg_len,
   input  logic [ARG_BYTES*8-1:0] arg_bytes,
   input  logic [7:0]             tbl_rsp_len,
   input  logic                   tbl_len_var,
   output logic                   rsp_done,
   output logic [7:0]             rsp_size,
   output logic [RSP_BYTES*8-1:0] rsp_bytes,
   output logic                   shutdown_req,
   output logic                   reset_req,
   output logic [15:0]            poll_mask,
   output logic                   poll_on
);
   import pwr_cmd_pkg::*;

   generate
      if (ARG_BYTES < 4) begin : g_bad_args
         $error("ARG_BYTES must be at least 4");
      end
      if (RSP_BYTES < 4) begin : g_bad_rsp
         $error("RSP_BYTES must be at least 4");
      end
      if (TICKS_PER_SEC < 1) begin : g_bad_ticks
         $error("TICKS_PER_SEC must be at least 1");
      end
   endgenerate

   logic [31:0]            now_sec;
   logic [7:0]             dec_size;
   logic [RSP_BYTES*8-1:0] dec_rsp;
   effect_t                dec_fx;

   pwr_rtc_keeper #(
      .TICKS_PER_SEC (TICKS_PER_SEC),
      .UNIX_START    (UNIX_START)
   ) u_rtc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (cmd_go & dec_fx.set_clk),
      .set_val (dec_fx.clk_val),
      .now_sec (now_sec)
   );

   pwr_cmd_decode #(
      .ARG_BYTES (ARG_BYTES),
      .RSP_BYTES (RSP_BYTES)
   ) u_dec (
      .op      (cmd_code),
      .arg_len (arg_len),
      .args    (arg_bytes),
      .tbl_len (tbl_rsp_len),
      .tbl_var (tbl_len_var),
      .now_sec (now_sec),
      .size    (dec_size),
      .rsp     (dec_rsp),
      .fx      (dec_fx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done     <= 1'b0;
         rsp_size     <= '0;
         rsp_bytes    <= '0;
         shutdown_req <= 1'b0;
         reset_req    <= 1'b0;
         poll_mask    <= '0;
         poll_on      <= 1'b0;
      end else begin
         rsp_done     <= cmd_go;
         shutdown_req <= cmd_go & dec_fx.halt;
         reset_req    <= cmd_go & dec_fx.restart;
         if (cmd_go) begin
            rsp_size  <= dec_size;
            rsp_bytes <= dec_rsp;
            if (dec_fx.poll_wr) begin
               if (dec_fx.poll_val != 16'h0000) begin
                  poll_mask <= dec_fx.poll_val;
                  poll_on   <= 1'b1;
               end else begin
                  poll_on   <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/pwr_cmd_exec_chk.sv
module pwr_cmd_exec_chk #(
   parameter int unsigned RSP_BYTES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_go,
   input logic                   rsp_done,
   input logic [7:0]             rsp_size,
   input logic [RSP_BYTES*8-1:0] rsp_bytes,
   input logic                   shutdown_req,
   input logic                   reset_req,
   input logic [15:0]            poll_mask,
   input logic                   poll_on
);

   a_r1_done_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> rsp_done);

   a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_go |=> !rsp_done);

   a_r5_halt_reply: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> (rsp_done && rsp_size == 8'd1 && rsp_bytes[7:0] == 8'h00));

   a_r6_restart_reply: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (rsp_done && rsp_size == 8'd0));

   a_r9_on_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      poll_on |-> (poll_mask != 16'h0000));

   a_r11_empty_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_size == 8'd0) |-> (rsp_bytes == '0));

   a_r12_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> ($stable(poll_mask) && $stable(poll_on)));

   a_r12_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({shutdown_req, reset_req}) <= 1);

endmodule

bind pwr_cmd_exec pwr_cmd_exec_chk #(.RSP_BYTES(RSP_BYTES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_go       (cmd_go),
   .rsp_done     (rsp_done),
   .rsp_size     (rsp_size),
   .rsp_bytes    (rsp_bytes),
   .shutdown_req (shutdown_req),
   .reset_req    (reset_req),
   .poll_mask    (poll_mask),
   .poll_on      (poll_on)
);

// File: tb/test_pwr_cmd_exec.sv
module test_pwr_cmd_exec;

   localparam int unsigned T      = 16;
   localparam logic [31:0] USTART = 32'd1000;
   localparam logic [31:0] EPOCH  = 32'd2082844800;

   typedef struct packed {
      logic [7:0]  op;
      logic [7:0]  len;
      logic [31:0] args;   // byte 0 in [31:24]
      logic [7:0]  tlen;
      logic        tvar;
      logic [7:0]  esize;
      logic [31:0] ebytes; // byte 0 in [31:24]
      logic        esd;
      logic        erst;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{8'hEA, 8'd0, 32'h0,          8'd0, 1'b0, 8'd1, 32'h01000000, 1'b0, 1'b0}, // R7
      '{8'hE2, 8'd2, 32'hFFFF0000,   8'd0, 1'b0, 8'd1, 32'h62000000, 1'b0, 1'b0}, // R7
      '{8'hDC, 8'd0, 32'h0,          8'd0, 1'b0, 8'd1, 32'h00000000, 1'b0, 1'b0}, // R7
      '{8'hDF, 8'd0, 32'h0,          8'd9, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R7
      '{8'h8F, 8'd1, 32'h00000000,   8'd0, 1'b0, 8'd2, 32'h00000000, 1'b0, 1'b0}, // R8
      '{8'h8F, 8'd1, 32'h03000000,   8'd0, 1'b0, 8'd2, 32'h00000000, 1'b0, 1'b0}, // R8
      '{8'h8F, 8'd2, 32'h01AA0000,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R8
      '{8'h8F, 8'd1, 32'h05000000,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R8
      '{8'h8F, 8'd0, 32'h00000000,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R8
      '{8'h8F, 8'd1, 32'h07000000,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R8
      '{8'h55, 8'd2, 32'hAABB0000,   8'd3, 1'b0, 8'd3, 32'h00000000, 1'b0, 1'b0}, // R10
      '{8'h56, 8'd0, 32'h0,          8'd5, 1'b1, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R10
      '{8'h38, 8'd1, 32'h11000000,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R2
      '{8'h7E, 8'd3, 32'h4D415400,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R5
      '{8'h7E, 8'd4, 32'h4D415458,   8'd0, 1'b0, 8'd1, 32'h00000000, 1'b0, 1'b0}, // R5
      '{8'h7E, 8'd4, 32'h4D415454,   8'd0, 1'b0, 8'd1, 32'h00000000, 1'b1, 1'b0}, // R5
      '{8'hD0, 8'd0, 32'h0,          8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b1}, // R6
      '{8'hD0, 8'd1, 32'h01000000,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R6
      '{8'h20, 8'd1, 32'h00000000,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}, // R9
      '{8'h30, 8'd3, 32'h12345600,   8'd0, 1'b0, 8'd0, 32'h00000000, 1'b0, 1'b0}  // R3
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_go = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic [7:0]  arg_len = '0;
   logic [31:0] arg_bytes = '0;
   logic [7:0]  tbl_rsp_len = '0;
   logic        tbl_len_var = 1'b0;
   logic        rsp_done;
   logic [7:0]  rsp_size;
   logic [31:0] rsp_bytes;
   logic        shutdown_req;
   logic        reset_req;
   logic [15:0] poll_mask;
   logic        poll_on;

   int checks = 0;
   int failures = 0;
   int unsigned cyc = 0;

   // clock model: value = base + cyc/T - base_sec
   logic [31:0] base = USTART + EPOCH;
   int unsigned base_sec = 0;

   logic [7:0]  got_size;
   logic [31:0] got_bytes;
   logic        got_sd;
   logic        got_rst;
   int unsigned go_cyc;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   pwr_cmd_exec #(
      .ARG_BYTES     (4),
      .RSP_BYTES     (4),
      .TICKS_PER_SEC (T),
      .UNIX_START    (USTART)
   ) i_pwr_cmd_exec (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_go       (cmd_go),
      .cmd_code     (cmd_code),
      .arg_len      (arg_len),
      .arg_bytes    (arg_bytes),
      .tbl_rsp_len  (tbl_rsp_len),
      .tbl_len_var  (tbl_len_var),
      .rsp_done     (rsp_done),
      .rsp_size     (rsp_size),
      .rsp_bytes    (rsp_bytes),
      .shutdown_req (shutdown_req),
      .reset_req    (reset_req),
      .poll_mask    (poll_mask),
      .poll_on      (poll_on)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] to_flat(input logic [31:0] msb_first);
      logic [31:0] f;
      for (int i = 0; i < 4; i++) f[8*i +: 8] = msb_first[31-8*i -: 8];
      return f;
   endfunction

   function automatic logic [31:0] clk_model(input int unsigned c);
      return base + 32'(c / T) - 32'(base_sec);
   endfunction

   // called at a negedge; returns at a negedge two cycles later
   task automatic issue(input logic [7:0] op, input logic [7:0] len,
                        input logic [31:0] args, input logic [7:0] tlen,
                        input logic tvar);
      cmd_code    = op;
      arg_len     = len;
      arg_bytes   = to_flat(args);
      tbl_rsp_len = tlen;
      tbl_len_var = tvar;
      cmd_go      = 1'b1;
      go_cyc      = cyc;
      @(negedge clk);
      cmd_go    = 1'b0;
      got_size  = rsp_size;
      got_bytes = rsp_bytes;
      got_sd    = shutdown_req;
      got_rst   = reset_req;
      check(rsp_done === 1'b1, "R1 done one cycle after dispatch", 64'(rsp_done), 64'd1);
      @(negedge clk);
      check(rsp_done === 1'b0 && shutdown_req === 1'b0 && reset_req === 1'b0,
            "R12 strobes low between dispatches",
            64'({rsp_done, shutdown_req, reset_req}), 64'd0);
   endtask

   task automatic read_clock(input string tag);
      logic [31:0] exp;
      issue(8'h38, 8'd0, 32'h0, 8'd0, 1'b0);
      exp = clk_model(go_cyc);
      check(got_size == 8'd4, tag, 64'(got_size), 64'd4);
      check(got_bytes == to_flat(exp), tag, 64'(got_bytes), 64'(to_flat(exp)));
   endtask

   task automatic set_clock(input logic [31:0] v);
      issue(8'h30, 8'd4, v, 8'd0, 1'b0);
      check(got_size == 8'd0, "R3 set reply empty", 64'(got_size), 64'd0);
      base     = v;
      base_sec = (go_cyc + 1) / T;
   endtask

   bit finished = 1'b0;

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R12)
      check(rsp_done === 1'b0 && shutdown_req === 1'b0 && reset_req === 1'b0 &&
            poll_on === 1'b0 && poll_mask === 16'h0 && rsp_size === 8'h0,
            "R12 reset state", 64'({rsp_done, shutdown_req, reset_req, poll_on, poll_mask, rsp_size}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: startup value plus elapsed seconds
      read_clock("R4 startup clock");
      repeat (3 * T + 5) @(negedge clk);
      read_clock("R4 clock advanced");

      // vector table: R5 R6 R7 R8 R9 R10 R11
      for (int v = 0; v < NV; v++) begin
         issue(VECS[v].op, VECS[v].len, VECS[v].args, VECS[v].tlen, VECS[v].tvar);
         check(got_size == VECS[v].esize, "R7/R8/R10 vector size",
               64'(got_size), 64'(VECS[v].esize));
         check(got_bytes == to_flat(VECS[v].ebytes), "R11 vector bytes",
               64'(got_bytes), 64'(to_flat(VECS[v].ebytes)));
         check(got_sd == VECS[v].esd, "R5 shutdown request", 64'(got_sd), 64'(VECS[v].esd));
         check(got_rst == VECS[v].erst, "R6 reset request", 64'(got_rst), 64'(VECS[v].erst));
      end

      // R3 wrong length above left the clock alone
      read_clock("R3 wrong length leaves clock");

      // R2: read on the wrap edge returns the pre-tick value
      while (cyc % T != T - 1) @(negedge clk);
      read_clock("R2 read at second boundary");

      // R3: set on the wrap edge, read right after returns the exact value
      while (cyc % T != T - 1) @(negedge clk);
      set_clock(32'h12345678);
      read_clock("R3 set on tick edge");
      repeat (2 * T + 3) @(negedge clk);
      read_clock("R3 clock runs after set");
      set_clock(32'hFFFFFFFE);
      repeat (3 * T) @(negedge clk);
      read_clock("R3 clock wraps");

      // R9 autopoll
      issue(8'h20, 8'd4, 32'h00861234, 8'd0, 1'b0);
      check(poll_on === 1'b1 && poll_mask === 16'h1234, "R9 autopoll enable",
            64'({poll_on, poll_mask}), 64'h11234);
      check(got_size == 8'd0, "R9 reply empty", 64'(got_size), 64'd0);
      issue(8'h20, 8'd4, 32'h00860000, 8'd0, 1'b0);
      check(poll_on === 1'b0 && poll_mask === 16'h1234, "R9 zero mask disables",
            64'({poll_on, poll_mask}), 64'h01234);
      issue(8'h20, 8'd5, 32'h00865555, 8'd0, 1'b0);
      check(poll_on === 1'b0 && poll_mask === 16'h1234, "R9 wrong length ignored",
            64'({poll_on, poll_mask}), 64'h01234);
      issue(8'h20, 8'd4, 32'h00875555, 8'd0, 1'b0);
      check(poll_on === 1'b0 && poll_mask === 16'h1234, "R9 other selector ignored",
            64'({poll_on, poll_mask}), 64'h01234);
      issue(8'h20, 8'd4, 32'h008600A5, 8'd0, 1'b0);
      check(poll_on === 1'b1 && poll_mask === 16'h00A5, "R9 re-enable",
            64'({poll_on, poll_mask}), 64'h100A5);

      // R1 back-to-back dispatch
      cmd_code = 8'hEA; arg_len = 8'd0; cmd_go = 1'b1;
      @(negedge clk);
      cmd_code = 8'hE2;
      @(negedge clk);
      check(rsp_done === 1'b1 && rsp_bytes[7:0] === 8'h62, "R1 back-to-back",
            64'({rsp_done, rsp_bytes[7:0]}), 64'h162);
      cmd_go = 1'b0;
      @(negedge clk);
      check(rsp_done === 1'b0, "R1 done drops", 64'(rsp_done), 64'd0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule